// File: doc/BRIEF.md
# Exchange-Add Instruction Byte Decoder

This block takes an instruction as a stream of bytes, one byte for each cycle in which `byteValid` is high. It recognises the exchange-and-add instruction: optional legacy prefixes for operand-size override (66h) and bus lock (F0h), an optional REX byte, the 0Fh escape, an opcode byte of C0h or C1h, and then the ModRM byte. Once the ModRM byte is taken, the block reports the operand width, the source and destination register indices, whether the destination is memory, and whether a lock was requested. It does not parse SIB, displacement or immediate bytes. Any other byte sequence is flagged as not recognised.

The operand width depends on three things: the low bit of the opcode, the W bit of a REX byte, and the processor mode input. A lock prefix only makes sense on a memory destination. When the destination is a register, the block raises an invalid-opcode fault and issues no operation. After every outcome (decoded, faulted or not recognised) the block returns to its idle state, so the next instruction can begin on the following byte.

Top module: `xadd_byte_decoder`

## Requirements
- R1: After reset, `done`, `udFault` and `notRecognised` are low, and the decoder waits for the first byte of an instruction.
- R2: `opSize` encodes the width as 0 = 8 bit, 1 = 16 bit, 2 = 32 bit and 3 = 64 bit. Opcode C0h gives 8 bit. Opcode C1h with no width prefix gives 32 bit.
- R3: A 66h prefix with opcode C1h and no active REX.W gives 16 bit. With opcode C0h it has no effect.
- R4: When `mode64` is high, a REX byte (40h–4Fh, bit 3 = W) with W = 1 and opcode C1h gives 64 bit. This takes priority over 66h.
- R5: `srcReg` = {REX bit 2, ModRM[5:3]} and `dstReg` = {REX bit 0, ModRM[2:0]}. Without an active REX byte, the top bit of each is 0.
- R6: `memDst` is 1 when ModRM[7:6] is not 11b, and 0 when it is 11b.
- R7: With an F0h prefix and a memory destination, `done` pulses and `lockReq` is 1. With F0h and a register destination, `udFault` pulses instead and `done` stays low.
- R8: `rexByteMap` is 1 only when opcode C0h was preceded by an active REX byte. In every other decode it is 0.
- R9: When `mode64` is low, a byte in 40h–4Fh is not a prefix: it pulses `notRecognised`. In this mode the width is never 64 bit.
- R10: A REX byte is active only when it immediately precedes 0Fh. A 66h or F0h byte after it discards it.
- R11: In the prefix position, any byte other than 66h, F0h, REX or 0Fh pulses `notRecognised`. After 0Fh, any byte other than C0h or C1h does the same.
- R12: `done` (or `udFault`) is a one-cycle pulse in the cycle after the ModRM byte is accepted. The decoder then takes a new instruction at once. Cycles with `byteValid` low do not advance decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode64 | input | 1 | High when the processor runs in 64-bit mode |
| byteValid | input | 1 | `byteIn` carries an instruction byte this cycle |
| byteIn | input | 8 | Instruction byte |
| done | output | 1 | One-cycle pulse: an operation was decoded |
| udFault | output | 1 | One-cycle pulse: lock used with a register destination |
| notRecognised | output | 1 | One-cycle pulse: the byte sequence is not this instruction |
| opSize | output | 2 | Operand width code |
| srcReg | output | 4 | Source register index |
| dstReg | output | 4 | Destination register index |
| memDst | output | 1 | Destination is a memory operand |
| lockReq | output | 1 | A lock prefix was present |
| rexByteMap | output | 1 | 8-bit registers use the REX mapping |

## Verification
The assertions assume that `mode64` does not change while an instruction is in flight, including the cycle in which its result appears. The stimulus changes the mode only between instructions, after the result pulse has been sampled. The assertions also assume bytes arrive only while the design is out of reset. The sweep feeds every combination of the prefixes, in a fixed legal order, across both opcodes and a spread of ModRM values. REX bytes appear only in 64-bit mode, except in the directed cases that test how 40h–4Fh bytes are rejected in legacy mode.

// File: rtl/xadd_dec_pkg.sv
package xadd_dec_pkg;

  localparam int BYTE_W      = 8;
  localparam int REG_FIELD_W = 3;
  localparam int REG_IDX_W   = REG_FIELD_W + 1;

  typedef enum logic [1:0] {SZ8 = 2'd0, SZ16 = 2'd1, SZ32 = 2'd2, SZ64 = 2'd3} opSizeT;

  typedef enum logic [1:0] {ST_PFX = 2'd0, ST_ESC = 2'd1, ST_MODRM = 2'd2} decStateT;

  typedef struct packed {
    logic clrAll;
    logic takeOpsz;
    logic takeLock;
    logic takeRex;
    logic dropRex;
    logic commitRex;
    logic takeOpcode;
    logic takeModrm;
    logic flagUnknown;
  } ctrlStrobeT;

endpackage

// File: rtl/xadd_dec_ctrl.sv
module xadd_dec_ctrl
  import xadd_dec_pkg::*;
#(
  parameter logic [BYTE_W-1:0] OPSZ_PFX = 8'h66,
  parameter logic [BYTE_W-1:0] LOCK_PFX = 8'hF0,
  parameter logic [BYTE_W-1:0] ESC_BYTE = 8'h0F,
  parameter logic [BYTE_W-1:0] OPC_NARROW = 8'hC0,
  parameter logic [BYTE_W-1:0] OPC_WIDE   = 8'hC1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mode64,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteIn,
  output ctrlStrobeT        strobe
);

  decStateT state, stateNext;
  logic     isRexByte;

  assign isRexByte = mode64 && (byteIn[BYTE_W-1:4] == 4'h4);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (byteValid) begin
      unique case (state)
        ST_PFX: begin
          if (byteIn == OPSZ_PFX) begin
            strobe.takeOpsz = 1'b1;
            strobe.dropRex  = 1'b1;
          end else if (byteIn == LOCK_PFX) begin
            strobe.takeLock = 1'b1;
            strobe.dropRex  = 1'b1;
          end else if (isRexByte) begin
            strobe.takeRex = 1'b1;
          end else if (byteIn == ESC_BYTE) begin
            strobe.commitRex = 1'b1;
            stateNext        = ST_ESC;
          end else begin
            strobe.flagUnknown = 1'b1;
            strobe.clrAll      = 1'b1;
          end
        end
        ST_ESC: begin
          if (byteIn == OPC_NARROW || byteIn == OPC_WIDE) begin
            strobe.takeOpcode = 1'b1;
            stateNext         = ST_MODRM;
          end else begin
            strobe.flagUnknown = 1'b1;
            strobe.clrAll      = 1'b1;
            stateNext          = ST_PFX;
          end
        end
        ST_MODRM: begin
          strobe.takeModrm = 1'b1;
          strobe.clrAll    = 1'b1;
          stateNext        = ST_PFX;
        end
        default: begin
          strobe.clrAll = 1'b1;
          stateNext     = ST_PFX;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_PFX;
    else       state <= stateNext;
  end

  // R12: after the ModRM byte the decoder is back at the prefix position
  a_r12_back_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MODRM && byteValid) |=> (state == ST_PFX));

  // R11: a byte after the escape always leaves the escape state
  a_r11_esc_leaves: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ESC && byteValid) |=> (state != ST_ESC));

  // R12: without a byte the state holds
  a_r12_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    !byteValid |=> $stable(state));

endmodule

// File: rtl/xadd_dec_datapath.sv
module xadd_dec_datapath
  import xadd_dec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 mode64,
  input  logic [BYTE_W-1:0]    byteIn,
  input  ctrlStrobeT           strobe,
  output logic                 done,
  output logic                 udFault,
  output logic                 notRecognised,
  output opSizeT               opSize,
  output logic [REG_IDX_W-1:0] srcReg,
  output logic [REG_IDX_W-1:0] dstReg,
  output logic                 memDst,
  output logic                 lockReq,
  output logic                 rexByteMap
);

  localparam int REX_W_BIT = 3;
  localparam int REX_R_BIT = 2;
  localparam int REX_B_BIT = 0;

  logic       opszSeen, lockSeen;
  logic       rexPendV, rexLiveV;
  logic [3:0] rexPendBits, rexLiveBits;
  logic       wideOp;

  logic       modrmIsReg;
  logic       regFault;
  opSizeT     sizeCalc;

  assign modrmIsReg = (byteIn[7:6] == 2'b11);
  assign regFault   = lockSeen && modrmIsReg;

  always_comb begin
    if (!wideOp)                                        sizeCalc = SZ8;
    else if (mode64 && rexLiveV && rexLiveBits[REX_W_BIT]) sizeCalc = SZ64;
    else if (opszSeen)                                  sizeCalc = SZ16;
    else                                                sizeCalc = SZ32;
  end

  // prefix collection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opszSeen    <= 1'b0;
      lockSeen    <= 1'b0;
      rexPendV    <= 1'b0;
      rexPendBits <= '0;
      rexLiveV    <= 1'b0;
      rexLiveBits <= '0;
      wideOp      <= 1'b0;
    end else begin
      if (strobe.takeOpsz) opszSeen <= 1'b1;
      if (strobe.takeLock) lockSeen <= 1'b1;
      if (strobe.takeRex) begin
        rexPendV    <= 1'b1;
        rexPendBits <= byteIn[3:0];
      end
      if (strobe.dropRex) rexPendV <= 1'b0;
      if (strobe.commitRex) begin
        rexLiveV    <= rexPendV;
        rexLiveBits <= rexPendV ? rexPendBits : 4'h0;
      end
      if (strobe.takeOpcode) wideOp <= byteIn[0];
      if (strobe.clrAll) begin
        opszSeen    <= 1'b0;
        lockSeen    <= 1'b0;
        rexPendV    <= 1'b0;
        rexPendBits <= '0;
        rexLiveV    <= 1'b0;
        rexLiveBits <= '0;
        wideOp      <= 1'b0;
      end
    end
  end

  // result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done          <= 1'b0;
      udFault       <= 1'b0;
      notRecognised <= 1'b0;
      opSize        <= SZ8;
      srcReg        <= '0;
      dstReg        <= '0;
      memDst        <= 1'b0;
      lockReq       <= 1'b0;
      rexByteMap    <= 1'b0;
    end else begin
      done          <= strobe.takeModrm && !regFault;
      udFault       <= strobe.takeModrm && regFault;
      notRecognised <= strobe.flagUnknown;
      if (strobe.takeModrm) begin
        opSize     <= sizeCalc;
        srcReg     <= {rexLiveV & rexLiveBits[REX_R_BIT], byteIn[5:3]};
        dstReg     <= {rexLiveV & rexLiveBits[REX_B_BIT], byteIn[2:0]};
        memDst     <= !modrmIsReg;
        lockReq    <= lockSeen;
        rexByteMap <= rexLiveV && !wideOp;
      end
    end
  end

  // R12: outcome pulses never overlap
  a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, udFault, notRecognised}));

  // R9: legacy mode never produces a 64-bit or REX-mapped result
  a_r9_legacy_narrow: assert property (@(posedge clk) disable iff (!rstN)
    (done && !mode64) |-> (opSize != SZ64 && !rexByteMap));

  // R8: REX byte mapping only accompanies the 8-bit form
  a_r8_map_narrow: assert property (@(posedge clk) disable iff (!rstN)
    (done && rexByteMap) |-> (opSize == SZ8));

  // R12: a pulse lasts one cycle
  a_r12_pulse_short: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/xadd_byte_decoder.sv
module xadd_byte_decoder
  import xadd_dec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 mode64,
  input  logic                 byteValid,
  input  logic [BYTE_W-1:0]    byteIn,
  output logic                 done,
  output logic                 udFault,
  output logic                 notRecognised,
  output logic [1:0]           opSize,
  output logic [REG_IDX_W-1:0] srcReg,
  output logic [REG_IDX_W-1:0] dstReg,
  output logic                 memDst,
  output logic                 lockReq,
  output logic                 rexByteMap
);

  ctrlStrobeT strobe;
  opSizeT     sizeOut;

  xadd_dec_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .mode64    (mode64),
    .byteValid (byteValid),
    .byteIn    (byteIn),
    .strobe    (strobe)
  );

  xadd_dec_datapath u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .mode64        (mode64),
    .byteIn        (byteIn),
    .strobe        (strobe),
    .done          (done),
    .udFault       (udFault),
    .notRecognised (notRecognised),
    .opSize        (sizeOut),
    .srcReg        (srcReg),
    .dstReg        (dstReg),
    .memDst        (memDst),
    .lockReq       (lockReq),
    .rexByteMap    (rexByteMap)
  );

  assign opSize = sizeOut;

  // R7: a fault only comes from a locked register destination
  a_r7_fault_cause: assert property (@(posedge clk) disable iff (!rstN)
    udFault |-> (lockReq && !memDst));

  // R7: a locked operation that issues has a memory destination
  a_r7_lock_mem: assert property (@(posedge clk) disable iff (!rstN)
    (done && lockReq) |-> memDst);

endmodule

// File: tb/test_xadd_byte_decoder.sv
module test_xadd_byte_decoder;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       mode64 = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] byteIn = 8'h00;
  logic       done, udFault, notRecognised, memDst, lockReq, rexByteMap;
  logic [1:0] opSize;
  logic [3:0] srcReg, dstReg;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xadd_byte_decoder i_xadd_byte_decoder (
    .clk(clk), .rstN(rstN), .mode64(mode64), .byteValid(byteValid), .byteIn(byteIn),
    .done(done), .udFault(udFault), .notRecognised(notRecognised), .opSize(opSize),
    .srcReg(srcReg), .dstReg(dstReg), .memDst(memDst), .lockReq(lockReq),
    .rexByteMap(rexByteMap)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic feed(input logic [7:0] b);
    @(negedge clk);
    byteValid = 1'b1;
    byteIn    = b;
  endtask

  task automatic idle();
    @(negedge clk);
    byteValid = 1'b0;
    byteIn    = 8'hEE;
  endtask

  // one full sweep case
  task automatic runCase(input bit m64, input bit osz, input bit lck, input bit rex,
                         input logic [3:0] rexBits, input bit wide, input logic [7:0] modrm);
    int  expSize;
    bit  fault;
    bit  rexW, rexR, rexB;
    rexW = rex && rexBits[3];
    rexR = rex && rexBits[2];
    rexB = rex && rexBits[0];
    mode64 = m64;
    if (osz) feed(8'h66);
    if (lck) feed(8'hF0);
    if (rex) feed({4'h4, rexBits});
    feed(8'h0F);
    feed(wide ? 8'hC1 : 8'hC0);
    feed(modrm);
    idle();
    fault = lck && (modrm[7:6] == 2'b11);
    if (!wide)            expSize = 0;
    else if (m64 && rexW) expSize = 3;
    else if (osz)         expSize = 1;
    else                  expSize = 2;
    if (fault) begin
      chk("R7 udFault", udFault, 1);
      chk("R7 done", done, 0);
    end else begin
      chk("R12 done", done, 1);
      chk("R7 udFault", udFault, 0);
      chk(!wide ? "R2 size" : (rexW && m64) ? "R4 size" : osz ? "R3 size" : "R2 size",
          opSize, expSize);
      chk("R5 src", srcReg, {rexR, modrm[5:3]});
      chk("R5 dst", dstReg, {rexB, modrm[2:0]});
      chk("R6 memDst", memDst, modrm[7:6] != 2'b11);
      chk("R7 lockReq", lockReq, lck);
      chk("R8 rexByteMap", rexByteMap, rex && !wide);
    end
    idle();
    chk("R12 pulse width", done | udFault, 0);
  endtask

  initial begin : watchdog
    while (cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset done", done, 0);
    chk("R1 reset udFault", udFault, 0);
    chk("R1 reset notRecognised", notRecognised, 0);
    rstN = 1'b1;
    idle();

    // sweep
    for (int m = 0; m < 2; m++)
      for (int o = 0; o < 2; o++)
        for (int l = 0; l < 2; l++)
          for (int r = 0; r < 9; r++)
            for (int w = 0; w < 2; w++)
              for (int mr = 0; mr < 256; mr += 7) begin
                if (m == 0 && r != 0) continue;
                runCase(m[0], o[0], l[0], r != 0, (r == 0) ? 4'h0 : 4'((r - 1) * 2 + 1),
                        w[0], 8'(mr));
              end

    // R4: every REX value with W set overrides 66
    for (int rv = 8; rv < 16; rv++) runCase(1'b1, 1'b1, 1'b0, 1'b1, 4'(rv), 1'b1, 8'hC3);

    // R9: 40h-4Fh in legacy mode is not a prefix
    mode64 = 1'b0;
    feed(8'h48);
    idle();
    chk("R9 legacy rex rejected", notRecognised, 1);
    feed(8'h48); feed(8'h0F);
    idle();
    chk("R9 no pulse after escape", notRecognised, 0);
    feed(8'hC1); feed(8'hD8);
    idle();
    chk("R9 escape after reject decodes", done, 1);
    chk("R9 width not 64", opSize, 2);

    // R10: REX followed by 66 is discarded
    mode64 = 1'b1;
    feed(8'h4D); feed(8'h66); feed(8'h0F); feed(8'hC1); feed(8'hE8);
    idle();
    chk("R10 done", done, 1);
    chk("R10 size 16 after dropped REX", opSize, 1);
    chk("R10 src top bit clear", srcReg, 4'h5);
    chk("R10 dst top bit clear", dstReg, 4'h0);
    // REX followed by F0 also discarded
    feed(8'h4C); feed(8'hF0); feed(8'h0F); feed(8'hC0); feed(8'h08);
    idle();
    chk("R10 map clear after F0", rexByteMap, 0);
    chk("R10 src after F0", srcReg, 4'h1);

    // R11: unknown first byte and unknown opcode after escape
    feed(8'h90);
    idle();
    chk("R11 unknown first byte", notRecognised, 1);
    idle();
    chk("R11 pulse width", notRecognised, 0);
    feed(8'h66); feed(8'h0F); feed(8'hB1);
    idle();
    chk("R11 unknown opcode", notRecognised, 1);
    chk("R11 no done", done, 0);
    feed(8'h0F); feed(8'hC1); feed(8'hC0);
    idle();
    chk("R11 prefix cleared after reject", opSize, 2);

    // R12: gaps with byteValid low do not disturb decoding
    feed(8'h48); idle(); idle(); feed(8'h0F); idle(); feed(8'hC1); idle();
    chk("R12 no early done", done, 0);
    feed(8'h1C);
    idle();
    chk("R12 done after gaps", done, 1);
    chk("R12 64 after gaps", opSize, 3);
    // back-to-back instructions
    feed(8'h0F); feed(8'hC0); feed(8'hC9); feed(8'h0F);
    chk("R12 back-to-back done", done, 1);
    feed(8'hC1); feed(8'h00);
    idle();
    chk("R12 second done", done, 1);
    chk("R12 second size", opSize, 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule